// File: doc/BRIEF.md
# 14-bit Four-Mode Timer

A programmable down-counter that divides an external timer clock and shapes one output line. Software loads a 14-bit count through a low byte register and a high byte register. The top two bits of the high byte carry a 2-bit output mode, which sits next to the count. A 2-bit command field in the command register controls the timer. It can load the staged count and mode and start counting, halt at once, halt at the next terminal count, or do nothing.

The output has two shapes. A square wave is high for the first half of each period of N timer clocks and low for the second half. A pulse output stays high and drops for one timer clock at terminal count. Each shape comes in a one-shot form and an auto-reload form. The timer clock is a separate input. It is synchronized into the host clock domain, and the counter advances once for each rising edge. When the timer is idle, stopped, or loaded with a count below 2, the output rests high.

Top module: `tmr4_top`

## Requirements
- R1: After reset the output is high and the timer is idle. It stays high until a start command with a legal count.
- R2: Writes use `wr_addr` 1 for the low byte and `wr_addr` 2 for the high byte. The count N is {high[5:0], low[7:0]} and the mode is high[7:6]. Both are copied into the running timer only by a start command. Byte writes made while running, and writes to address 3, leave the current waveform unchanged.
- R3: In square-wave modes the output is high for ceil(N/2) timer clocks and then low for floor(N/2) timer clocks. For odd N the high half is one clock longer.
- R4: Mode 00 produces one square-wave period and then holds high and idle. Mode 01 repeats the period without a gap by reloading N.
- R5: In pulse modes the output is low for exactly the last timer clock of each N-clock period and high otherwise. Mode 10 gives one such pulse and then holds high. Mode 11 repeats it every N timer clocks.
- R6: A command register write (`wr_addr` 0) uses wr_data[7:6] as the command. Code 01 halts the timer immediately, and the output goes high and stays high.
- R7: Command code 10 lets the running period finish, then halts at terminal count with the output high, even in an auto-reload mode. Given while idle, it has no effect on a later start.
- R8: Command code 11 loads the staged count and mode and starts from the beginning of a period. Given while running, it restarts with the newly staged values.
- R9: Command code 00 has no effect on a running waveform, and command bits 5:0 are ignored.
- R10: A start with N of 0 or 1 leaves the timer idle with the output held high.
- R11: The counter advances only on rising edges of `tmr_clk_in`. A level held high or low, or no edges at all, leaves the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one host cycle per write |
| wr_addr | input | 2 | 0 command, 1 count low byte, 2 count high byte and mode, 3 unused |
| wr_data | input | 8 | Write data |
| tmr_clk_in | input | 1 | External timer clock to be divided |
| tmr_out | output | 1 | Shaped timer output |

## Verification
The hardest case to reach from the ports is a halt-at-terminal-count command that lands in the middle of an auto-reload period. The timer must then finish that period and stop, rather than stop at once or keep reloading. The stimulus reaches this case by starting a continuous pulse with a known count and issuing a known number of timer clock edges. It then writes the command at a chosen phase and compares every later timer period against a model that forces the output high from the next period boundary onward. A pending halt left behind while idle is covered in the same way: a one-shot run started after it must complete unaffected.

// File: rtl/tmr4_pkg.sv
package tmr4_pkg;
  localparam int CNT_W  = 14;
  localparam int BYTE_W = 8;
  localparam int HI_W   = CNT_W - BYTE_W;
  localparam int MODE_W = 2;
  localparam int ADDR_W = 2;
  localparam int CMD_W  = 2;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP     = 2'b00,
    CMD_HALT    = 2'b01,
    CMD_HALT_TC = 2'b10,
    CMD_START   = 2'b11
  } cmd_e;

  typedef enum logic [ADDR_W-1:0] {
    A_CMD   = 2'd0,
    A_LO    = 2'd1,
    A_HI    = 2'd2,
    A_SPARE = 2'd3
  } addr_e;

  typedef struct packed {
    logic pulse;
    logic cont;
  } mode_t;

  function automatic cnt_t join_count(input byte_t hi, input byte_t lo);
    return {hi[HI_W-1:0], lo};
  endfunction

  function automatic mode_t join_mode(input byte_t hi);
    return mode_t'(hi[BYTE_W-1 -: MODE_W]);
  endfunction

  function automatic logic count_ok(input cnt_t n);
    return n >= cnt_t'(2);
  endfunction

  function automatic logic square_high(input cnt_t cnt, input cnt_t n);
    return cnt > (n >> 1);
  endfunction

  function automatic logic pulse_high(input cnt_t cnt);
    return cnt != cnt_t'(1);
  endfunction

  function automatic logic is_terminal(input cnt_t cnt);
    return cnt <= cnt_t'(1);
  endfunction
endpackage

// File: rtl/tmr4_tick.sv
module tmr4_tick #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tmr_clk_in,
  output logic tick
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN_W-2:0], tmr_clk_in};
  end

  assign tick = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/tmr4_regs.sv
module tmr4_regs
  import tmr4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  byte_t             wr_data,
  output cnt_t              stage_n,
  output mode_t             stage_mode
);
  byte_t lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_en) begin
      case (addr_e'(wr_addr))
        A_LO:    lo_q <= wr_data;
        A_HI:    hi_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign stage_n    = join_count(hi_q, lo_q);
  assign stage_mode = join_mode(hi_q);
endmodule

// File: rtl/tmr4_core.sv
module tmr4_core
  import tmr4_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  cmd_wr,
  input  cmd_e  cmd,
  input  cnt_t  stage_n,
  input  mode_t stage_mode,
  output logic  running,
  output cnt_t  cnt,
  output cnt_t  cur_n,
  output mode_t cur_mode
);
  logic stop_pend;
  logic terminal;

  assign terminal = is_terminal(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      cnt       <= '0;
      cur_n     <= '0;
      cur_mode  <= '0;
      stop_pend <= 1'b0;
    end else begin
      if (running && tick) begin
        if (terminal) begin
          if (cur_mode.cont && !stop_pend) begin
            cnt <= cur_n;
          end else begin
            running   <= 1'b0;
            stop_pend <= 1'b0;
          end
        end else begin
          cnt <= cnt - cnt_t'(1);
        end
      end
      if (cmd_wr) begin
        case (cmd)
          CMD_START: begin
            cur_n     <= stage_n;
            cur_mode  <= stage_mode;
            cnt       <= stage_n;
            running   <= count_ok(stage_n);
            stop_pend <= 1'b0;
          end
          CMD_HALT: begin
            running   <= 1'b0;
            stop_pend <= 1'b0;
          end
          CMD_HALT_TC: begin
            if (running) stop_pend <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr4_wave.sv
module tmr4_wave
  import tmr4_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  running,
  input  cnt_t  cnt,
  input  cnt_t  cur_n,
  input  mode_t cur_mode,
  output logic  tmr_out
);
  logic level;

  always_comb begin
    if (!running)           level = 1'b1;
    else if (cur_mode.pulse) level = pulse_high(cnt);
    else                    level = square_high(cnt, cur_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tmr_out <= 1'b1;
    else        tmr_out <= level;
  end
endmodule

// File: rtl/tmr4_top.sv
module tmr4_top
  import tmr4_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              tmr_clk_in,
  output logic              tmr_out
);
  logic             tick;
  logic             cmd_wr;
  logic [CMD_W-1:0] cmd_code;
  cnt_t             stage_n;
  mode_t            stage_mode;
  logic             running;
  cnt_t             cnt;
  cnt_t             cur_n;
  mode_t            cur_mode;

  assign cmd_wr   = wr_en && (addr_e'(wr_addr) == A_CMD);
  assign cmd_code = wr_data[BYTE_W-1 -: CMD_W];

  tmr4_tick #(.STAGES(SYNC_STAGES)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_clk_in (tmr_clk_in),
    .tick       (tick)
  );

  tmr4_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .stage_n    (stage_n),
    .stage_mode (stage_mode)
  );

  tmr4_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cmd_wr     (cmd_wr),
    .cmd        (cmd_e'(cmd_code)),
    .stage_n    (stage_n),
    .stage_mode (stage_mode),
    .running    (running),
    .cnt        (cnt),
    .cur_n      (cur_n),
    .cur_mode   (cur_mode)
  );

  tmr4_wave u_wave (
    .clk      (clk),
    .rst_n    (rst_n),
    .running  (running),
    .cnt      (cnt),
    .cur_n    (cur_n),
    .cur_mode (cur_mode),
    .tmr_out  (tmr_out)
  );
endmodule

// File: rtl/tmr4_chk.sv
module tmr4_chk
  import tmr4_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             running,
  input logic             cmd_wr,
  input logic [CMD_W-1:0] cmd_code,
  input cnt_t             cnt,
  input cnt_t             cur_n,
  input cnt_t             stage_n,
  input mode_t            cur_mode,
  input logic             tmr_out
);
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt >= cnt_t'(1) && cnt <= cur_n));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && cnt > cnt_t'(1) && !cmd_wr) |=> (cnt == $past(cnt) - cnt_t'(1)));

  p_hold_no_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && !cmd_wr) |=> $stable(cnt));

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> tmr_out);

  p_halt_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_code == 2'b01) |=> !running);

  p_illegal_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_code == 2'b11 && stage_n < cnt_t'(2)) |=> !running);

  p_start_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_code == 2'b11 && stage_n >= cnt_t'(2)) |=> (running && cnt == $past(stage_n)));

  p_pulse_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cur_mode.pulse && cnt != cnt_t'(1)) |=> tmr_out);
endmodule

bind tmr4_top tmr4_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .running  (running),
  .cmd_wr   (cmd_wr),
  .cmd_code (cmd_code),
  .cnt      (cnt),
  .cur_n    (cur_n),
  .stage_n  (stage_n),
  .cur_mode (cur_mode),
  .tmr_out  (tmr_out)
);

// File: tb/tmr4_top_tb_top.sv
module tmr4_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       tmr_clk_in = 1'b0;
  logic       tmr_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr4_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .tmr_clk_in (tmr_clk_in),
    .tmr_out    (tmr_out)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Expected level after j timer edges since start.
  function automatic logic model(input int mode, input int n, input int j);
    int ph;
    if (n < 2) return 1'b1;
    if ((mode % 2) == 0 && j >= n) return 1'b1;
    ph = j % n;
    if (mode >= 2) return (ph != n - 1);
    return (ph < (n + 1) / 2);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic start(input int mode, input int n);
    wr(2'd2, {mode[1:0], n[13:8]});
    wr(2'd1, n[7:0]);
    wr(2'd0, 8'hC0);
    settle();
  endtask

  task automatic tpulse();
    tmr_clk_in = 1'b1;
    repeat (4) @(negedge clk);
    tmr_clk_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input string tag, input int periods, input int mode,
                     input int n, input int j0, input int stop_at);
    for (int k = 0; k < periods; k++) begin
      int j;
      logic e;
      j = j0 + k;
      e = model(mode, n, j);
      if (stop_at >= 0 && j >= stop_at) e = 1'b1;
      check($sformatf("%s j=%0d", tag, j), tmr_out, e);
      tpulse();
    end
  endtask

  task automatic t_reset();
    check("R1 reset level", tmr_out, 1'b1);
    run("R1 idle with edges", 4, 0, 0, 0, 0);
  endtask

  task automatic t_cont_square();
    start(1, 6);
    run("R3 R4 mode01 N=6", 18, 1, 6, 0, -1);
  endtask

  task automatic t_single_square();
    start(0, 5);
    run("R3 R4 mode00 N=5 odd", 10, 0, 5, 0, -1);
  endtask

  task automatic t_single_pulse();
    start(2, 4);
    run("R5 mode10 N=4", 10, 2, 4, 0, -1);
  endtask

  task automatic t_cont_pulse();
    start(3, 3);
    run("R5 mode11 N=3", 12, 3, 3, 0, -1);
  endtask

  task automatic t_wide_count();
    start(0, 259);
    run("R2 R3 mode00 N=259", 265, 0, 259, 0, -1);
  endtask

  task automatic t_staging_restart();
    start(1, 4);
    run("R2 before staging", 3, 1, 4, 0, -1);
    wr(2'd2, 8'h40);
    wr(2'd1, 8'h09);
    wr(2'd3, 8'hFF);
    run("R2 staging ignored", 9, 1, 4, 3, -1);
    wr(2'd0, 8'hC0);
    settle();
    run("R8 restart N=9", 12, 1, 9, 0, -1);
  endtask

  task automatic t_nop();
    start(3, 3);
    run("R9 before nop", 4, 3, 3, 0, -1);
    wr(2'd0, 8'h3F);
    run("R9 after nop", 8, 3, 3, 4, -1);
  endtask

  task automatic t_halt_now();
    start(1, 6);
    run("R6 before halt", 4, 1, 6, 0, -1);
    wr(2'd0, 8'h40);
    settle();
    run("R6 halted", 10, 1, 6, 4, 0);
    wr(2'd0, 8'h80);
    run("R7 halt_tc idle", 4, 1, 6, 0, 0);
    start(2, 3);
    run("R7 start after idle halt_tc", 6, 2, 3, 0, -1);
  endtask

  task automatic t_halt_tc();
    start(3, 5);
    run("R7 before halt_tc", 7, 3, 5, 0, -1);
    wr(2'd0, 8'h80);
    run("R7 finish then stop", 10, 3, 5, 7, 10);
  endtask

  task automatic t_illegal();
    start(1, 0);
    run("R10 N=0", 8, 1, 0, 0, 0);
    start(3, 1);
    run("R10 N=1", 8, 3, 1, 0, 0);
  endtask

  task automatic t_levels();
    start(1, 2);
    repeat (20) @(negedge clk);
    check("R11 no edges", tmr_out, 1'b1);
    tmr_clk_in = 1'b1;
    repeat (20) @(negedge clk);
    check("R11 after one rise", tmr_out, 1'b0);
    repeat (20) @(negedge clk);
    check("R11 held high", tmr_out, 1'b0);
    tmr_clk_in = 1'b0;
    repeat (20) @(negedge clk);
    check("R11 held low", tmr_out, 1'b0);
    tmr_clk_in = 1'b1;
    repeat (20) @(negedge clk);
    check("R11 second rise", tmr_out, 1'b1);
    tmr_clk_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_cont_square();
    t_single_square();
    t_single_pulse();
    t_cont_pulse();
    t_wide_count();
    t_staging_restart();
    t_nop();
    t_halt_now();
    t_halt_tc();
    t_illegal();
    t_levels();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule